// File: doc/BRIEF.md
# Compact 8-bit I/O Processor Core

This block is a small processor meant to take the place of hand-written state machines that poll and drive peripherals. It fetches fixed-width 16-bit instructions through a synchronous program memory read port addressed by a 12-bit program counter. It works on 8-bit registers and exchanges bytes with peripherals over an 8-bit address, 8-bit data bus that has separate read and write strobes.

Each instruction runs through a fixed four-clock sequence: address out, instruction capture, and two execute clocks. A peripheral strobe is held for both execute clocks. The register space holds eight writable registers next to three read-only constant codes. A zero flag set by the ALU steers the conditional jumps. A return stack, whose depth is a build parameter, supports subroutine calls.

Top module: `iop_core`

## Requirements
- R1: After reset `prog_addr_o` is 0, both strobes are low and all registers and the zero flag are 0. Every instruction occupies exactly four clocks. `prog_addr_o` holds the program counter and changes only on the fourth clock edge of an instruction, so it reads k after 4k rising edges of straight-line code.
- R2: Instruction fields are: opcode in bits [15:12], register code in [11:8], 8-bit immediate or port in [7:0], jump target in [11:0]. Opcodes are 0 no-op, 1 load immediate, 2 AND, 3 OR, 4 XOR, 5 ADD, 6 port read, 7 port write, 8 jump, 9 jump if zero, 10 jump if not zero, 11 call, 12 return. Codes 13 to 15 act as no-ops.
- R3: Load immediate writes the immediate field into the selected register.
- R4: The AND, OR, XOR and ADD opcodes combine the register with the immediate (ADD is modulo 256), write the result back and set the zero flag exactly when the result is 0. No other opcode changes the zero flag.
- R5: Register codes 0 to 7 are writable. Codes 8, 9 and 10 read as 0x00, 0x01 and 0xFF, and codes 11 to 15 read as 0x00. Writes to codes 8 to 15 have no effect.
- R6: A port read drives `io_addr_o` with the immediate and raises `io_rd_o` for exactly two clocks (clocks 3 and 4 of the instruction). The byte on `io_rdata_i` in the last strobe clock is written to the selected register.
- R7: A port write drives `io_addr_o` with the immediate and `io_wdata_o` with the selected register, and raises `io_wr_o` for exactly two clocks.
- R8: Jump loads the target unconditionally. Jump if zero loads it only when the zero flag is 1, and jump if not zero only when it is 0. Otherwise the counter steps by one.
- R9: Call pushes the counter plus one and jumps, and return pops into the counter. A push onto a full stack discards the oldest entry. A return on an empty stack steps by one. With `STACK_DEPTH` = 0, call and return are no-ops.
- R10: `io_rd_o` and `io_wr_o` are never high together, and both stay low outside port instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_addr_o | output | 12 | Program memory address (program counter) |
| prog_data_i | input | 16 | Instruction word, one clock after the address |
| io_addr_o | output | 8 | Peripheral port address |
| io_wdata_o | output | 8 | Peripheral write data |
| io_rdata_i | input | 8 | Peripheral read data |
| io_rd_o | output | 1 | Peripheral read strobe |
| io_wr_o | output | 1 | Peripheral write strobe |

## Verification
The core runs short directed programs and one long seeded random program. Every port write is compared, in order, against a bench instruction model, together with the final program counter. A program made only of no-ops separates fetch timing from everything else. A load-and-dump program over all sixteen register codes shows whether constant reads and ignored writes are decoded correctly. Flag-driven branch sequences check the zero flag. Too deep a call chain, followed by extra returns, checks the overflow and underflow handling of the stack. The random mix of ALU, load, port and short conditional-skip instructions brings out result, flag and read-capture errors that the directed cases miss.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int IW = 16;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_LDI  = 4'd1;
  localparam logic [3:0] OP_ANDI = 4'd2;
  localparam logic [3:0] OP_ORI  = 4'd3;
  localparam logic [3:0] OP_XORI = 4'd4;
  localparam logic [3:0] OP_ADDI = 4'd5;
  localparam logic [3:0] OP_IORD = 4'd6;
  localparam logic [3:0] OP_IOWR = 4'd7;
  localparam logic [3:0] OP_JMP  = 4'd8;
  localparam logic [3:0] OP_JZ   = 4'd9;
  localparam logic [3:0] OP_JNZ  = 4'd10;
  localparam logic [3:0] OP_CALL = 4'd11;
  localparam logic [3:0] OP_RET  = 4'd12;

  localparam logic [1:0] PH_ADDR  = 2'd0;
  localparam logic [1:0] PH_LATCH = 2'd1;
  localparam logic [1:0] PH_EXEC  = 2'd2;
  localparam logic [1:0] PH_DONE  = 2'd3;

  typedef enum logic [1:0] {ALU_AND, ALU_OR, ALU_XOR, ALU_ADD} alu_op_e;
endpackage

// File: rtl/iop_regfile.sv
module iop_regfile #(
  parameter int DW   = 8,
  parameter int RW   = 4,
  parameter int NGPR = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  localparam int GW = (NGPR > 1) ? $clog2(NGPR) : 1;
  localparam logic [RW-1:0] GPR_LIM = RW'(NGPR);
  localparam logic [RW-1:0] K_ZERO  = RW'(NGPR);
  localparam logic [RW-1:0] K_ONE   = RW'(NGPR + 1);
  localparam logic [RW-1:0] K_ONES  = RW'(NGPR + 2);

  logic [NGPR-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (we_i && (waddr_i < GPR_LIM)) regs_q[waddr_i[GW-1:0]] <= wdata_i;
  end

  always_comb begin
    if (raddr_i < GPR_LIM) rdata_o = regs_q[raddr_i[GW-1:0]];
    else begin
      case (raddr_i)
        K_ONE:   rdata_o = DW'(1);
        K_ONES:  rdata_o = '1;
        K_ZERO:  rdata_o = '0;
        default: rdata_o = '0;
      endcase
    end
  end

  assert_const_wr_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i >= GPR_LIM) |=> $stable(regs_q));
endmodule

// File: rtl/iop_alu.sv
module iop_alu
  import iop_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o,
  output logic          zero_o
);
  always_comb begin
    case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/iop_retstack.sv
module iop_retstack #(
  parameter int DEPTH = 4,
  parameter int AW    = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_o,
  output logic          empty_o
);
  if (DEPTH == 0) begin : g_none
    assign top_o   = '0;
    assign empty_o = 1'b1;
  end else begin : g_stack
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    logic [DEPTH-1:0][AW-1:0] stk_q;
    logic [CW-1:0]            cnt_q;

    // entry 0 is the top; a push onto a full stack drops the deepest entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stk_q <= '0;
        cnt_q <= '0;
      end else if (push_i) begin
        for (int i = DEPTH - 1; i > 0; i--) stk_q[i] <= stk_q[i-1];
        stk_q[0] <= push_addr_i;
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && cnt_q != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) stk_q[i] <= stk_q[i+1];
        stk_q[DEPTH-1] <= '0;
        cnt_q <= cnt_q - 1'b1;
      end
    end

    assign top_o   = stk_q[0];
    assign empty_o = (cnt_q == '0);

    assert_depth_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= FULL);
    assert_push_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i |=> (stk_q[0] == $past(push_addr_i)) && !empty_o);
  end
endmodule

// File: rtl/iop_core.sv
module iop_core
  import iop_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int DW          = 8,
  parameter int NGPR        = 8,
  parameter int STACK_DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PC_W-1:0] prog_addr_o,
  input  logic [IW-1:0]   prog_data_i,
  output logic [DW-1:0]   io_addr_o,
  output logic [DW-1:0]   io_wdata_o,
  input  logic [DW-1:0]   io_rdata_i,
  output logic            io_rd_o,
  output logic            io_wr_o
);
  localparam int RW = 4;

  logic [1:0]      phase_q;
  logic [PC_W-1:0] pc_q, pc_nxt, stk_top;
  logic [IW-1:0]   ir_q;
  logic            zf_q, stk_empty, push, pop, last, is_alu, we, alu_zero;
  logic [3:0]      op;
  logic [RW-1:0]   rsel;
  logic [DW-1:0]   imm, rdata, alu_y, wdata;
  logic [PC_W-1:0] tgt;

  assign op   = ir_q[15:12];
  assign rsel = ir_q[11:8];
  assign imm  = ir_q[DW-1:0];
  assign tgt  = ir_q[PC_W-1:0];
  assign last = (phase_q == PH_DONE);
  assign is_alu = (op >= OP_ANDI) && (op <= OP_ADDI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ADDR;
      pc_q    <= '0;
      ir_q    <= '0;
      zf_q    <= 1'b0;
    end else begin
      phase_q <= phase_q + 2'd1;
      if (phase_q == PH_LATCH) ir_q <= prog_data_i;
      if (last) begin
        pc_q <= pc_nxt;
        if (is_alu) zf_q <= alu_zero;
      end
    end
  end

  iop_regfile #(.DW(DW), .RW(RW), .NGPR(NGPR)) u_regs (
    .clk_i, .rst_ni, .raddr_i(rsel), .rdata_o(rdata),
    .we_i(we), .waddr_i(rsel), .wdata_i(wdata)
  );

  iop_alu #(.DW(DW)) u_alu (
    .op_i(alu_op_e'(op[1:0] - 2'd2)), .a_i(rdata), .b_i(imm),
    .y_o(alu_y), .zero_o(alu_zero)
  );

  iop_retstack #(.DEPTH(STACK_DEPTH), .AW(PC_W)) u_stack (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .push_addr_i(pc_q + 1'b1),
    .top_o(stk_top), .empty_o(stk_empty)
  );

  assign we    = last && (is_alu || op == OP_LDI || op == OP_IORD);
  assign wdata = (op == OP_LDI) ? imm : (op == OP_IORD) ? io_rdata_i : alu_y;

  always_comb begin
    pc_nxt = pc_q + 1'b1;
    push   = 1'b0;
    pop    = 1'b0;
    case (op)
      OP_JMP:  pc_nxt = tgt;
      OP_JZ:   if (zf_q) pc_nxt = tgt;
      OP_JNZ:  if (!zf_q) pc_nxt = tgt;
      OP_CALL: if (STACK_DEPTH > 0) begin
        pc_nxt = tgt;
        push   = last;
      end
      OP_RET:  if (!stk_empty) begin
        pc_nxt = stk_top;
        pop    = last;
      end
      default: ;
    endcase
  end

  // strobes span the two execute clocks
  assign prog_addr_o = pc_q;
  assign io_addr_o   = imm;
  assign io_wdata_o  = rdata;
  assign io_rd_o     = phase_q[1] && (op == OP_IORD);
  assign io_wr_o     = phase_q[1] && (op == OP_IOWR);

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_rd_o && io_wr_o));
  assert_pc_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(prog_addr_o));
  assert_rd_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_rd_o) |=> io_rd_o);
  assert_rd_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_o && $past(io_rd_o)) |=> !io_rd_o);
  assert_wr_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_wr_o) |=> io_wr_o && $stable(io_addr_o) && $stable(io_wdata_o));
  assert_zf_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(last && is_alu) |=> $stable(zf_q));
endmodule

// File: tb/iop_core_bench.sv
module iop_core_bench;
  localparam int SD = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] prog_addr;
  logic [15:0] prog_data = '0;
  logic [7:0]  io_addr, io_wdata, io_rdata;
  logic        io_rd, io_wr;

  always #5 clk = ~clk;

  function automatic logic [7:0] dev_resp(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'hC3;
  endfunction

  logic [15:0] mem [4096];
  always @(posedge clk) prog_data <= mem[prog_addr];
  assign io_rdata = dev_resp(io_addr);

  iop_core #(.STACK_DEPTH(SD)) u_iop_core (
    .clk_i(clk), .rst_ni(rst_ni), .prog_addr_o(prog_addr), .prog_data_i(prog_data),
    .io_addr_o(io_addr), .io_wdata_o(io_wdata), .io_rdata_i(io_rdata),
    .io_rd_o(io_rd), .io_wr_o(io_wr)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [3:0] r, input logic [7:0] v);
    return {op, r, v};
  endfunction
  function automatic logic [15:0] jmp(input logic [3:0] op, input logic [11:0] t);
    return {op, t};
  endfunction

  // observed port writes and strobe monitor
  logic [7:0] obs_a [1024], obs_d [1024];
  int obs_n = 0, rd_run = 0, wr_run = 0, both_seen = 0;
  int rd_bad = 0, wr_bad = 0, rd_cnt = 0, wr_cnt = 0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      rd_run = 0; wr_run = 0;
    end else begin
      if (io_rd && io_wr) both_seen++;
      if (io_wr) begin
        if (wr_run == 0 && obs_n < 1024) begin
          obs_a[obs_n] = io_addr; obs_d[obs_n] = io_wdata; obs_n++;
        end
        wr_run++;
      end else if (wr_run != 0) begin
        wr_cnt++; if (wr_run != 2) wr_bad++; wr_run = 0;
      end
      if (io_rd) rd_run++;
      else if (rd_run != 0) begin
        rd_cnt++; if (rd_run != 2) rd_bad++; rd_run = 0;
      end
    end
  end

  // instruction model built from the requirements
  logic [7:0]  m_regs [8];
  logic [11:0] m_pc, m_stk [SD];
  logic        m_zf;
  int          m_cnt;
  logic [7:0]  exp_a [1024], exp_d [1024];
  int          exp_n;

  function automatic logic [7:0] m_rd(input logic [3:0] r);
    if (r < 8) return m_regs[r[2:0]];
    if (r == 9) return 8'h01;
    if (r == 10) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic model_run(input int n);
    for (int i = 0; i < 8; i++) m_regs[i] = 0;
    m_pc = 0; m_zf = 0; m_cnt = 0; exp_n = 0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] w; logic [3:0] op, r; logic [7:0] v, res; logic [11:0] nx;
      w = mem[m_pc]; op = w[15:12]; r = w[11:8]; v = w[7:0]; nx = m_pc + 1;
      case (op)
        4'd1: if (r < 8) m_regs[r[2:0]] = v;
        4'd2, 4'd3, 4'd4, 4'd5: begin
          case (op)
            4'd2: res = m_rd(r) & v;
            4'd3: res = m_rd(r) | v;
            4'd4: res = m_rd(r) ^ v;
            default: res = m_rd(r) + v;
          endcase
          if (r < 8) m_regs[r[2:0]] = res;
          m_zf = (res == 0);
        end
        4'd6: if (r < 8) m_regs[r[2:0]] = dev_resp(v);
        4'd7: begin exp_a[exp_n] = v; exp_d[exp_n] = m_rd(r); exp_n++; end
        4'd8: nx = w[11:0];
        4'd9: if (m_zf) nx = w[11:0];
        4'd10: if (!m_zf) nx = w[11:0];
        4'd11: if (SD > 0) begin
          for (int j = SD - 1; j > 0; j--) m_stk[j] = m_stk[j-1];
          m_stk[0] = m_pc + 1; if (m_cnt < SD) m_cnt++;
          nx = w[11:0];
        end
        4'd12: if (m_cnt > 0) begin
          nx = m_stk[0];
          for (int j = 0; j < SD - 1; j++) m_stk[j] = m_stk[j+1];
          m_cnt--;
        end
        default: ;
      endcase
      m_pc = nx;
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    obs_n = 0; both_seen = 0; rd_bad = 0; wr_bad = 0; rd_cnt = 0; wr_cnt = 0;
    rst_ni = 1'b1;
  endtask

  task automatic run_prog(input int n, input string tag);
    model_run(n);
    do_reset();
    repeat (4 * n) @(posedge clk);
    @(negedge clk);
    chk(obs_n == exp_n, {tag, " write count"}, obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      chk(obs_a[i] == exp_a[i], {tag, " R7 write port"}, obs_a[i], exp_a[i]);
      chk(obs_d[i] == exp_d[i], {tag, " write data"}, obs_d[i], exp_d[i]);
    end
    chk(prog_addr == m_pc, {tag, " R1 final pc"}, prog_addr, m_pc);
    chk(both_seen == 0, {tag, " R10 strobe overlap"}, both_seen, 0);
    chk(wr_bad == 0, {tag, " R7 write strobe width"}, wr_bad, 0);
    chk(rd_bad == 0, {tag, " R6 read strobe width"}, rd_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    clear_mem();

    // R1: reset state and four-clock cadence on no-op code
    @(negedge clk);
    chk(prog_addr == 0, "R1 reset pc", prog_addr, 0);
    chk(!io_rd && !io_wr, "R1 R10 reset strobes", {io_rd, io_wr}, 0);
    do_reset();
    repeat (3) @(posedge clk); @(negedge clk);
    chk(prog_addr == 0, "R1 pc held for 3 clocks", prog_addr, 0);
    @(posedge clk); @(negedge clk);
    chk(prog_addr == 1, "R1 pc after 4 clocks", prog_addr, 1);
    repeat (4) @(posedge clk); @(negedge clk);
    chk(prog_addr == 2, "R1 pc after 8 clocks", prog_addr, 2);

    // R3 R5: load every code, dump all sixteen
    clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = ins(4'd1, 4'(i), 8'(8'h31 + 8'(i) * 8'd17));
    for (int i = 0; i < 16; i++) mem[16 + i] = ins(4'd7, 4'(i), 8'(8'h40 + i));
    mem[32] = jmp(4'd8, 12'd32);
    run_prog(36, "R3 R5 regs");

    // R4 R8: ALU results, zero flag and conditional jumps
    clear_mem();
    mem[0]  = ins(4'd1, 4'd1, 8'h01);
    mem[1]  = ins(4'd5, 4'd1, 8'hFF);   // wraps to 0, flag set
    mem[2]  = jmp(4'd9, 12'd4);          // taken
    mem[3]  = ins(4'd7, 4'd1, 8'hE0);   // skipped
    mem[4]  = ins(4'd7, 4'd1, 8'hE1);
    mem[5]  = ins(4'd1, 4'd2, 8'hF0);   // load keeps flag
    mem[6]  = jmp(4'd10, 12'd8);         // not taken
    mem[7]  = ins(4'd4, 4'd2, 8'h0F);   // xor -> FF, flag clear
    mem[8]  = jmp(4'd9, 12'd10);         // not taken
    mem[9]  = jmp(4'd10, 12'd11);        // taken
    mem[10] = ins(4'd7, 4'd2, 8'hE2);   // skipped
    mem[11] = ins(4'd2, 4'd2, 8'h3C);
    mem[12] = ins(4'd3, 4'd2, 8'h81);
    mem[13] = ins(4'd7, 4'd2, 8'hE3);
    mem[14] = jmp(4'd8, 12'd16);
    mem[15] = ins(4'd7, 4'd2, 8'hE4);   // skipped
    mem[16] = ins(4'd6, 4'd3, 8'h5A);   // R6 port read
    mem[17] = ins(4'd7, 4'd3, 8'hE5);
    mem[18] = ins(4'd15, 4'd0, 8'h00);  // unused opcode
    mem[19] = jmp(4'd8, 12'd19);
    run_prog(24, "R4 R6 R8 flow");

    // R9: call chain one deeper than the stack, extra returns
    clear_mem();
    mem[0] = jmp(4'd11, 12'h100);
    mem[1] = ins(4'd1, 4'd0, 8'hEE);
    mem[2] = ins(4'd7, 4'd0, 8'h30);
    mem[3] = jmp(4'd8, 12'd3);
    for (int k = 0; k < 5; k++) begin
      int a; a = 12'h100 + 16 * k;
      mem[a]     = ins(4'd1, 4'd0, 8'(k));
      mem[a + 1] = ins(4'd7, 4'd0, 8'(8'h10 + k));
      mem[a + 2] = (k < 4) ? jmp(4'd11, 12'(a + 16)) : 16'h0000;
      mem[a + 3] = ins(4'd1, 4'd0, 8'(8'h80 + k));
      mem[a + 4] = ins(4'd7, 4'd0, 8'(8'h20 + k));
      mem[a + 5] = jmp(4'd12, 12'd0);
    end
    mem[12'h150] = jmp(4'd8, 12'h150);
    run_prog(140, "R9 stack");

    // R2 R3 R4 R5 R6 R7: seeded random instruction mix
    clear_mem();
    for (int i = 0; i < 240; i++) begin
      int sel; sel = $urandom_range(0, 9);
      case (sel)
        0, 1: mem[i] = ins(4'd1, 4'($urandom_range(0, 15)), 8'($urandom));
        2, 3, 4: mem[i] = ins(4'($urandom_range(2, 5)), 4'($urandom_range(0, 15)), 8'($urandom));
        5: mem[i] = ins(4'd6, 4'($urandom_range(0, 15)), 8'($urandom));
        6, 7: mem[i] = ins(4'd7, 4'($urandom_range(0, 15)), 8'($urandom));
        8: mem[i] = jmp(4'($urandom_range(9, 10)), 12'(i + 2));
        default: mem[i] = ins(4'($urandom_range(13, 15)), 4'($urandom), 8'($urandom));
      endcase
    end
    for (int i = 0; i < 8; i++) mem[240 + i] = ins(4'd7, 4'(i), 8'(8'hA0 + i));
    mem[248] = jmp(4'd8, 12'd248);
    run_prog(260, "R2 R4 random");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule